// File: doc/BRIEF.md
# ATM Connection Address Compression Lookup

This block turns the routing fields of an incoming ATM cell header into the address of its connection record. The lookup walks two tables held in a shared word-wide memory. First, the line number and VPI bits are concatenated into a key, and a programmable path mask picks bits out of it. The picked bits are packed densely into a path pointer, which indexes the path-level table.

The path entry holds two things: a channel-table offset and a 10-bit channel mask. The same bit-gathering rule is then applied to the VCI to form a channel pointer. The channel-level entry is read at `chan_base + offset*4 + pointer*4`.

A cell that cannot be resolved is reported as misinserted and counted in a saturating discard counter. There are three causes:
- an invalid path entry;
- an invalid channel entry;
- when the strict-bits mode is on, a VCI with a 1 in a position the mask does not select.

A small four-state controller sequences the walk with one cell in flight:
- `ST_IDLE`: ready for a header. It goes to `ST_VP_READ` on `in_valid`.
- `ST_VP_READ`: issues the path read, then waits one cycle for data. From there it goes to `ST_VC_READ` for a usable entry, or to `ST_DONE` on a miss.
- `ST_VC_READ`: issues the channel read, waits one cycle, then goes to `ST_DONE`.
- `ST_DONE`: presents the result for one cycle, then returns to `ST_IDLE`.

Top module: `atm_vc_lookup`

## Requirements
- R1: The channel pointer is formed by taking the low 10 VCI bits at every position where the channel mask is 1 and packing them, lowest position first, into the pointer's low bits (VCI 0x0031 with mask 0x037 gives pointer 0x19).
- R2: The channel entry byte address is `chan_base + offset*4 + pointer*4` (base 0x0084_0000, offset 0x100, pointer 0x19 give 0x0084_0464). On a hit, `out_addr` carries this address and `out_data` carries the entry word read there.
- R3: The path pointer gathers the bits of the key `{in_phy, in_vpi}` selected by `cfg_vp_mask`, using the rule of R1; VPI bits outside the mask do not affect the result. The path entry is read at `cfg_vp_base + pointer*4`. A path entry has its valid flag in bit 31, the channel mask in bits [25:16] and the channel-table offset in bits [15:0].
- R4: A channel entry has its valid flag in bit 31. If that flag is clear, the cell is reported with `out_miss`=1.
- R5: When `cfg_check_unalloc`=1, a VCI with any 1 where the channel mask is 0 (including VCI bits 10 and above) is a miss, and no channel read is issued. When `cfg_check_unalloc`=0, those bits have no effect on the result.
- R6: A path entry with bit 31 clear gives a miss, and no channel read is issued.
- R7: `discard_cnt` rises by one when a result with `out_miss`=1 is presented. It saturates at its maximum. `discard_clr` zeroes it synchronously and takes priority over an increment.
- R8: `in_ready` is high only in `ST_IDLE`, so one cell is in flight at a time. `out_valid` is a single-cycle pulse.
- R9: Counting from the edge that accepts a header, `out_valid` rises after 4 clock edges for a walk that reaches the channel table, and after 2 edges for a path-stage miss. Every memory read strobe lasts one cycle.
- R10: After reset, `in_ready`=1, `out_valid`=0, `mem_rd_en`=0 and `discard_cnt`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_vp_base | input | ADDR_W | Byte base of the path-level table |
| cfg_vp_mask | input | PHY_W+VPI_W | Bit-select mask over `{in_phy, in_vpi}` |
| cfg_vc_base | input | ADDR_W | Byte base of the channel-level tables |
| cfg_check_unalloc | input | 1 | Strict-bits mode: treat unselected VCI ones as a miss |
| in_valid | input | 1 | Header present |
| in_ready | output | 1 | Block accepts a header |
| in_phy | input | PHY_W | Line number of the cell |
| in_vpi | input | VPI_W | Path identifier |
| in_vci | input | VCI_W | Channel identifier |
| mem_rd_en | output | 1 | Table read strobe |
| mem_rd_addr | output | ADDR_W | Table read byte address |
| mem_rd_data | input | 32 | Table word, valid the cycle after the strobe |
| out_valid | output | 1 | Result pulse |
| out_miss | output | 1 | Cell is misinserted |
| out_addr | output | ADDR_W | Channel entry byte address on a hit |
| out_data | output | 32 | Channel entry word on a hit |
| discard_clr | input | 1 | Synchronous clear of the discard counter |
| discard_cnt | output | CNT_W | Saturating misinserted-cell count |

## Verification
Two situations are hard to reach from the ports.

The first is a strict-bits miss caused only by VCI bits above the 10-bit mask width. A cell with that VCI must be sent once with the mode on and once with it off. The two latencies and the two addresses then show whether the high bits were checked or ignored.

The second is the collision between clear and an increment. It needs the counter already pinned at its ceiling by a run of path misses. A further miss is then sent with `discard_clr` held high across the cycle in which the result is presented, and the counter must read zero afterwards.

// File: rtl/atm_lkp_pkg.sv
package atm_lkp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_VP_READ = 2'd1,
        ST_VC_READ = 2'd2,
        ST_DONE    = 2'd3
    } lkp_state_t;

    // Table word layout
    localparam int ENTRY_W     = 32;
    localparam int ENT_VALID   = 31;
    localparam int ENT_OFF_LO  = 0;
    localparam int ENT_OFF_W   = 16;
    localparam int ENT_MASK_LO = 16;
    localparam int ENT_MASK_W  = 10;
    localparam int WORD_SHIFT  = 2;

endpackage

// File: rtl/lkp_bit_gather.sv
// Packs the src bits selected by mask into the low bits of dense_o,
// lowest selected position first.
module lkp_bit_gather #(
    parameter int W = 10
) (
    input  logic [W-1:0] src,
    input  logic [W-1:0] mask,
    output logic [W-1:0] dense_o
);
    localparam int CW = $clog2(W + 1);

    logic [CW-1:0] rank [W];

    // rank[i] = number of mask ones below position i
    always_comb begin
        rank[0] = '0;
        for (int i = 1; i < W; i++) begin
            rank[i] = rank[i-1] + CW'(mask[i-1]);
        end
    end

    for (genvar j = 0; j < W; j++) begin : g_slot
        logic hit;
        always_comb begin
            hit = 1'b0;
            for (int i = 0; i < W; i++) begin
                if (mask[i] && (rank[i] == CW'(j))) begin
                    hit = hit | src[i];
                end
            end
        end
        assign dense_o[j] = hit;
    end

endmodule

// File: rtl/lkp_discard_ctr.sv
module lkp_discard_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc && (count != CNT_MAX)) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/atm_vc_lookup.sv
module atm_vc_lookup
    import atm_lkp_pkg::*;
#(
    parameter  int PHY_W  = 2,
    parameter  int VPI_W  = 8,
    parameter  int VCI_W  = 16,
    parameter  int ADDR_W = 32,
    parameter  int CNT_W  = 16,
    localparam int KEY_W  = PHY_W + VPI_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_vp_base,
    input  logic [KEY_W-1:0]  cfg_vp_mask,
    input  logic [ADDR_W-1:0] cfg_vc_base,
    input  logic              cfg_check_unalloc,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [PHY_W-1:0]  in_phy,
    input  logic [VPI_W-1:0]  in_vpi,
    input  logic [VCI_W-1:0]  in_vci,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [31:0]       mem_rd_data,
    output logic              out_valid,
    output logic              out_miss,
    output logic [ADDR_W-1:0] out_addr,
    output logic [31:0]       out_data,
    input  logic              discard_clr,
    output logic [CNT_W-1:0]  discard_cnt
);

    lkp_state_t state, state_nx;

    logic                  rd_wait;
    logic [KEY_W-1:0]      key_q;
    logic [VCI_W-1:0]      vci_q;
    logic [ENT_OFF_W-1:0]  vc_off_q;
    logic [ENT_MASK_W-1:0] vc_mask_q;
    logic                  res_miss_q;
    logic [ADDR_W-1:0]     res_addr_q;
    logic [ENTRY_W-1:0]    res_data_q;

    logic [KEY_W-1:0]      vp_ptr;
    logic [ENT_MASK_W-1:0] vc_ptr;
    logic [ADDR_W-1:0]     vp_addr;
    logic [ADDR_W-1:0]     vc_addr;
    logic [ENT_MASK_W-1:0] ent_mask;
    logic                  ent_valid;
    logic                  stray_bits;
    logic                  vp_reject;
    logic                  accept;
    logic                  vp_decide;
    logic                  vc_decide;

    // Bit-gather units: path key and channel identifier
    lkp_bit_gather #(.W(KEY_W)) u_vp_gather (
        .src     (key_q),
        .mask    (cfg_vp_mask),
        .dense_o (vp_ptr)
    );

    lkp_bit_gather #(.W(ENT_MASK_W)) u_vc_gather (
        .src     (vci_q[ENT_MASK_W-1:0]),
        .mask    (vc_mask_q),
        .dense_o (vc_ptr)
    );

    // Address and entry decode
    always_comb begin
        vp_addr    = cfg_vp_base + (ADDR_W'(vp_ptr) << WORD_SHIFT);
        vc_addr    = cfg_vc_base
                   + (ADDR_W'(vc_off_q) << WORD_SHIFT)
                   + (ADDR_W'(vc_ptr) << WORD_SHIFT);
        ent_mask   = mem_rd_data[ENT_MASK_LO +: ENT_MASK_W];
        ent_valid  = mem_rd_data[ENT_VALID];
        stray_bits = |(vci_q & ~VCI_W'(ent_mask));
        vp_reject  = !ent_valid || (cfg_check_unalloc && stray_bits);
        accept     = (state == ST_IDLE) && in_valid;
        vp_decide  = (state == ST_VP_READ) && rd_wait;
        vc_decide  = (state == ST_VC_READ) && rd_wait;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (in_valid) state_nx = ST_VP_READ;
            ST_VP_READ: if (rd_wait)  state_nx = vp_reject ? ST_DONE : ST_VC_READ;
            ST_VC_READ: if (rd_wait)  state_nx = ST_DONE;
            ST_DONE:                  state_nx = ST_IDLE;
            default:                  state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        in_ready    = (state == ST_IDLE);
        mem_rd_en   = ((state == ST_VP_READ) || (state == ST_VC_READ)) && !rd_wait;
        mem_rd_addr = (state == ST_VC_READ) ? vc_addr : vp_addr;
        out_valid   = (state == ST_DONE);
        out_miss    = res_miss_q;
        out_addr    = res_addr_q;
        out_data    = res_data_q;
    end

    // Walk datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_wait    <= 1'b0;
            key_q      <= '0;
            vci_q      <= '0;
            vc_off_q   <= '0;
            vc_mask_q  <= '0;
            res_miss_q <= 1'b0;
            res_addr_q <= '0;
            res_data_q <= '0;
        end else begin
            rd_wait <= (state_nx == state) ? (rd_wait | mem_rd_en) : 1'b0;
            if (accept) begin
                key_q <= {in_phy, in_vpi};
                vci_q <= in_vci;
            end
            if (vp_decide) begin
                vc_off_q   <= mem_rd_data[ENT_OFF_LO +: ENT_OFF_W];
                vc_mask_q  <= ent_mask;
                res_miss_q <= vp_reject;
                res_addr_q <= '0;
                res_data_q <= '0;
            end
            if (vc_decide) begin
                res_miss_q <= !ent_valid;
                res_addr_q <= vc_addr;
                res_data_q <= mem_rd_data;
            end
        end
    end

    lkp_discard_ctr #(.CNT_W(CNT_W)) u_discard (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (discard_clr),
        .inc   (out_valid && out_miss),
        .count (discard_cnt)
    );

endmodule

// File: rtl/lkp_checker.sv
module lkp_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             mem_rd_en,
    input logic             out_valid,
    input logic             out_miss,
    input logic [31:0]      out_data,
    input logic             discard_clr,
    input logic [CNT_W-1:0] discard_cnt
);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    p_one_in_flight_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> !in_ready);

    p_out_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    p_busy_at_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    p_read_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

    p_hit_entry_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_miss |-> out_data[31]);

    p_miss_counts_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_miss && !discard_clr && (discard_cnt != CMAX)
        |=> discard_cnt == CNT_W'($past(discard_cnt) + 1'b1));

    p_saturate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (discard_cnt == CMAX) && !discard_clr |=> discard_cnt == CMAX);

    p_clear_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        discard_clr |=> discard_cnt == '0);

    p_count_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !discard_clr && !(out_valid && out_miss) |=> $stable(discard_cnt));

endmodule

bind atm_vc_lookup lkp_checker #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .mem_rd_en   (mem_rd_en),
    .out_valid   (out_valid),
    .out_miss    (out_miss),
    .out_data    (out_data),
    .discard_clr (discard_clr),
    .discard_cnt (discard_cnt)
);

// File: tb/sim_atm_vc_lookup.sv
`timescale 1ns/1ps
module sim_atm_vc_lookup;

    localparam int CNT_W = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_vp_base = 32'h0;
    logic [9:0]  cfg_vp_mask = 10'b11_0000_0011;
    logic [31:0] cfg_vc_base = 32'h0084_0000;
    logic        cfg_check_unalloc = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  in_phy = '0;
    logic [7:0]  in_vpi = '0;
    logic [15:0] in_vci = '0;
    logic        mem_rd_en;
    logic [31:0] mem_rd_addr;
    logic [31:0] mem_rd_data = '0;
    logic        out_valid;
    logic        out_miss;
    logic [31:0] out_addr;
    logic [31:0] out_data;
    logic        discard_clr = 1'b0;
    logic [CNT_W-1:0] discard_cnt;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    atm_vc_lookup #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_vp_base(cfg_vp_base), .cfg_vp_mask(cfg_vp_mask),
        .cfg_vc_base(cfg_vc_base), .cfg_check_unalloc(cfg_check_unalloc),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_phy(in_phy), .in_vpi(in_vpi), .in_vci(in_vci),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .out_valid(out_valid), .out_miss(out_miss),
        .out_addr(out_addr), .out_data(out_data),
        .discard_clr(discard_clr), .discard_cnt(discard_cnt)
    );

    // Table memory: 4096 words, one-cycle read
    logic [31:0] mem [4096];
    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[13:2]];
    end

    // {phy, vpi, vci, strict, miss, latency, addr, data}
    localparam int VW = 95;
    localparam logic [VW-1:0] VECS [12] = '{
        {2'd0, 8'h00, 16'h0031, 1'b0, 1'b0, 3'd4, 32'h0084_0464, 32'h8000_0119},
        {2'd0, 8'h00, 16'h0031, 1'b1, 1'b0, 3'd4, 32'h0084_0464, 32'h8000_0119},
        {2'd0, 8'h00, 16'h0039, 1'b1, 1'b1, 3'd2, 32'h0,         32'h0},
        {2'd0, 8'h00, 16'h0039, 1'b0, 1'b0, 3'd4, 32'h0084_0464, 32'h8000_0119},
        {2'd0, 8'h00, 16'h0431, 1'b1, 1'b1, 3'd2, 32'h0,         32'h0},
        {2'd0, 8'h00, 16'h0431, 1'b0, 1'b0, 3'd4, 32'h0084_0464, 32'h8000_0119},
        {2'd0, 8'h01, 16'h0155, 1'b0, 1'b0, 3'd4, 32'h0084_0D54, 32'h8000_0355},
        {2'd0, 8'h01, 16'h0010, 1'b0, 1'b1, 3'd4, 32'h0,         32'h0},
        {2'd0, 8'h02, 16'h0001, 1'b0, 1'b1, 3'd2, 32'h0,         32'h0},
        {2'd1, 8'h01, 16'h0300, 1'b0, 1'b0, 3'd4, 32'h0084_010C, 32'h8000_0043},
        {2'd1, 8'hFD, 16'h0200, 1'b1, 1'b0, 3'd4, 32'h0084_0108, 32'h8000_0042},
        {2'd0, 8'h01, 16'h03FF, 1'b1, 1'b0, 3'd4, 32'h0084_17FC, 32'h8000_05FF}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_cell(input logic [1:0] phy, input logic [7:0] vpi,
                             input logic [15:0] vci, input logic strict,
                             output logic miss, output logic [31:0] addr,
                             output logic [31:0] data, output int lat);
        @(negedge clk);
        cfg_check_unalloc = strict;
        in_phy = phy; in_vpi = vpi; in_vci = vci; in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check("R8 ready drops after accept", 32'(in_ready), 32'd0);
        lat = 0;
        miss = 1'b0; addr = '0; data = '0;
        for (int k = 0; k < 20; k++) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (out_valid) begin
                miss = out_miss; addr = out_addr; data = out_data;
                break;
            end
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic        m;
        logic [31:0] a, d;
        int          lat;

        for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
        // Path entries (R3 layout): valid[31], mask[25:16], offset[15:0]
        mem[0] = {1'b1, 5'b0, 10'h037, 16'h0100};
        mem[1] = {1'b1, 5'b0, 10'h3FF, 16'h0200};
        mem[5] = {1'b1, 5'b0, 10'h300, 16'h0040};
        for (int i = 16'h40; i < 16'h600; i++) mem[i] = 32'h8000_0000 | 32'(i);
        mem[16'h210] = 32'h0000_0210;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 reset state
        check("R10 in_ready", 32'(in_ready), 32'd1);
        check("R10 out_valid", 32'(out_valid), 32'd0);
        check("R10 mem_rd_en", 32'(mem_rd_en), 32'd0);
        check("R10 discard_cnt", 32'(discard_cnt), 32'd0);
        rst_n = 1'b1;

        // Vector table: R1 R2 R3 R4 R5 R6 R9
        for (int v = 0; v < 12; v++) begin
            logic [VW-1:0] e;
            e = VECS[v];
            send_cell(e[94:93], e[92:85], e[84:69], e[68], m, a, d, lat);
            check($sformatf("R4/R5/R6 miss vec%0d", v), 32'(m), 32'(e[67]));
            check($sformatf("R9 latency vec%0d", v), 32'(lat), 32'(e[66:64]));
            if (!e[67]) begin
                check($sformatf("R1/R2/R3 addr vec%0d", v), a, e[63:32]);
                check($sformatf("R2 data vec%0d", v), d, e[31:0]);
            end
        end

        // R7: four misses so far
        check("R7 count after table", 32'(discard_cnt), 32'd4);
        @(negedge clk); discard_clr = 1'b1;
        @(negedge clk); discard_clr = 1'b0;
        check("R7 clear", 32'(discard_cnt), 32'd0);

        // R7 saturation: nine path misses on a 3-bit counter
        for (int n = 0; n < 9; n++) send_cell(2'd0, 8'h02, 16'h0001, 1'b0, m, a, d, lat);
        check("R7 saturate", 32'(discard_cnt), 32'd7);

        // R7 clear wins over a simultaneous increment
        @(negedge clk); discard_clr = 1'b1;
        send_cell(2'd0, 8'h02, 16'h0001, 1'b0, m, a, d, lat);
        discard_clr = 1'b0;
        @(negedge clk);
        check("R7 clear priority", 32'(discard_cnt), 32'd0);

        // R3: unmasked VPI bits ignored, hit still counts nothing
        send_cell(2'd1, 8'h55, 16'h0100, 1'b1, m, a, d, lat);
        check("R3 masked key addr", a, 32'h0084_0101 + 32'd3);
        check("R7 hit not counted", 32'(discard_cnt), 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule